// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a display timing generator and a parallel RGB panel. Each pixel clock it takes one 24-bit pixel together with horizontal sync, vertical sync and data-enable. It first rearranges the three colour channels into a chosen order. It then packs the result into one of several 16, 18 or 24-bit pin layouts on a 24-bit panel data bus. The packed data and the three control strobes are registered before they leave the block.

A single memory-mapped control word sets the behaviour. It selects the channel order, the pin layout, and a polarity flip for the pixel clock. For each of hsync, vsync and data-enable it also sets a polarity flip, launch on the falling clock edge, and forcing the signal inactive. A mode bit makes the data-enable pin carry composite sync. An enable bit gates the whole output. Any address other than the control word reads back a fixed identification constant.

Top module: `rgb_panel_fmt`

## Requirements
- R1: A write with `cfg_we` high to address `CTRL_ADDR` (default 0) loads `cfg_wdata[16:0]` into the control word on that clock edge. Reading `CTRL_ADDR` returns the control word in bits 16:0 and zeros above. Reset clears the control word to 0.
- R2: A read from any address other than `CTRL_ADDR` returns 32'h00647069.
- R3: While control bit 0 (enable) is 0, `pnl_data`, `pnl_hs`, `pnl_vs`, `pnl_de` and `pnl_clk` are all low.
- R4: Control bits 15:14 set the channel order. The three 8-bit slots from high to low are: 0 = {R,G,B}, 1 = {B,G,R}, 2 = {G,R,B}, 3 = {B,R,G}. R is pixel bits 23:16, G is 15:8 and B is 7:0.
- R5: Control bits 13:11 set the layout. Slot values are cut to their top 5 bits (5-bit fields) or top 6 bits (6-bit fields). Code 1 gives {8'b0, s2[7:3], s1[7:2], s0[7:3]}. Code 2 gives {3'b0, s2[7:3], 2'b0, s1[7:2], 3'b0, s0[7:3]}. Code 3 gives {2'b0, s2[7:3], 3'b0, s1[7:2], 2'b0, s0[7:3], 1'b0}.
- R6: Layout code 4 gives {6'b0, s2[7:2], s1[7:2], s0[7:2]}. Code 5 gives {2'b0, s2[7:2], 2'b0, s1[7:2], 2'b0, s0[7:2]}.
- R7: Layout code 6 gives {s2, s1, s0}. Codes 0 and 7 drive the data bus to zero.
- R8: Control bits 9, 8 and 7 invert the hsync, vsync and data-enable pins.
- R9: Control bits 3, 2 and 1 force hsync, vsync and data-enable inactive. The forced pin equals its invert bit.
- R10: Control bits 6, 5 and 4 move hsync, vsync and data-enable onto the falling edge of the clock. Such a pin changes half a cycle after the rising-edge value it carries.
- R11: With control bit 16 set, the data-enable pin carries hsync XOR vsync instead of data-enable. The invert and disable bits for data-enable still apply.
- R12: With enable set, `pnl_clk` follows `clk`. With control bit 10 set, it follows the inverse of `clk`.
- R13: Data and rising-edge control outputs show the input pixel one clock edge after it was captured. When enable is 0, the output registers are cleared, so a 0-to-1 enable edge restarts from a cleared pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| pix_rgb | input | 24 | Incoming pixel, R in 23:16, G in 15:8, B in 7:0 |
| pix_hs | input | 1 | Incoming horizontal sync |
| pix_vs | input | 1 | Incoming vertical sync |
| pix_de | input | 1 | Incoming data-enable |
| pnl_data | output | 24 | Packed panel data |
| pnl_hs | output | 1 | Panel horizontal sync |
| pnl_vs | output | 1 | Panel vertical sync |
| pnl_de | output | 1 | Panel data-enable or composite sync |
| pnl_clk | output | 1 | Panel pixel clock |

## Verification
A wrong channel order or layout shows on `pnl_data` one clock after the pixel that exposes it. Random pixels make almost every bit of such a fault visible within a few cycles of selecting the mode. A wrong half-cycle launch appears as a one-sample lag, or a missing lag, on the affected strobe against its rising-edge value. A wrong invert or disable bit appears on the next sampled strobe level. A control word that fails to load or clear shows at once on the read port. It also shows as outputs that stay high while the block is disabled.

// File: rtl/rgbfmt_pkg.sv
package rgbfmt_pkg;
    localparam int CH_W    = 8;
    localparam int BUS_W   = 3 * CH_W;
    localparam int NSIG    = 3;          // index 2 hsync, 1 vsync, 0 data-enable
    localparam int CTRL_W  = 17;

    typedef struct packed {
        logic            csync_mode;     // 16
        logic [1:0]      order;          // 15:14
        logic [2:0]      fmt;            // 13:11
        logic            clk_inv;        // 10
        logic [NSIG-1:0] inv;            // 9:7
        logic [NSIG-1:0] neg;            // 6:4
        logic [NSIG-1:0] dis;            // 3:1
        logic            en;             // 0
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [BUS_W-1:0] data;
        logic [NSIG-1:0]  sig;
        logic             clk_inv;
    } state_t;
endpackage

// File: rtl/rgbfmt_order.sv
module rgbfmt_order
    import rgbfmt_pkg::*;
(
    input  logic [1:0]       order,
    input  logic [BUS_W-1:0] pix,
    output logic [BUS_W-1:0] slots
);
    logic [CH_W-1:0] r, g, b;
    assign r = pix[3*CH_W-1:2*CH_W];
    assign g = pix[2*CH_W-1:CH_W];
    assign b = pix[CH_W-1:0];

    always_comb begin
        unique case (order)
            2'd0:    slots = {r, g, b};
            2'd1:    slots = {b, g, r};
            2'd2:    slots = {g, r, b};
            default: slots = {b, r, g};
        endcase
    end
endmodule

// File: rtl/rgbfmt_pack.sv
module rgbfmt_pack
    import rgbfmt_pkg::*;
(
    input  logic [2:0]       fmt,
    input  logic [BUS_W-1:0] slots,
    output logic [BUS_W-1:0] bus
);
    logic [CH_W-1:0] s2, s1, s0;
    assign s2 = slots[3*CH_W-1:2*CH_W];
    assign s1 = slots[2*CH_W-1:CH_W];
    assign s0 = slots[CH_W-1:0];

    always_comb begin
        unique case (fmt)
            3'd1:    bus = {8'b0, s2[7:3], s1[7:2], s0[7:3]};
            3'd2:    bus = {3'b0, s2[7:3], 2'b0, s1[7:2], 3'b0, s0[7:3]};
            3'd3:    bus = {2'b0, s2[7:3], 3'b0, s1[7:2], 2'b0, s0[7:3], 1'b0};
            3'd4:    bus = {6'b0, s2[7:2], s1[7:2], s0[7:2]};
            3'd5:    bus = {2'b0, s2[7:2], 2'b0, s1[7:2], 2'b0, s0[7:2]};
            3'd6:    bus = slots;
            default: bus = '0;
        endcase
    end

    // R5 R6: packed layouts leave the top pins unused
    always_comb begin
        if (fmt == 3'd1 || fmt == 3'd4) begin
            narrow_top_zero_chk: assert (bus[BUS_W-1:BUS_W-6] == 6'b0);
        end
    end
endmodule

// File: rtl/rgbfmt_launch.sv
module rgbfmt_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic neg,
    input  logic rise_q,
    output logic pin
);
    logic fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= en ? rise_q : 1'b0;
    end

    assign pin = neg ? fall_q : rise_q;

    // R10
    fall_stage_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg && en) |-> (pin == rise_q));
endmodule

// File: rtl/rgb_panel_fmt.sv
module rgb_panel_fmt
    import rgbfmt_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          CTRL_ADDR = 0,
    parameter logic [31:0] ID_WORD   = 32'h0064_7069
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [BUS_W-1:0]  pix_rgb,
    input  logic              pix_hs,
    input  logic              pix_vs,
    input  logic              pix_de,
    output logic [BUS_W-1:0]  pnl_data,
    output logic              pnl_hs,
    output logic              pnl_vs,
    output logic              pnl_de,
    output logic              pnl_clk
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    state_t st_d, st_q;
    logic [BUS_W-1:0] slots, packed_w;
    logic [NSIG-1:0]  src, pins;
    logic             ctrl_hit;

    assign ctrl_hit = (cfg_addr == CTRL_A);

    rgbfmt_order u_order (.order(st_q.ctrl.order), .pix(pix_rgb), .slots(slots));
    rgbfmt_pack  u_pack  (.fmt(st_q.ctrl.fmt), .slots(slots), .bus(packed_w));

    assign src = {pix_hs, pix_vs, st_q.ctrl.csync_mode ? (pix_hs ^ pix_vs) : pix_de};

    always_comb begin
        st_d = st_q;
        if (cfg_we && ctrl_hit) st_d.ctrl = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        st_d.data    = '0;
        st_d.sig     = '0;
        st_d.clk_inv = 1'b0;
        if (st_q.ctrl.en) begin
            st_d.data    = packed_w;
            st_d.sig     = (src & ~st_q.ctrl.dis) ^ st_q.ctrl.inv;
            st_d.clk_inv = st_q.ctrl.clk_inv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NSIG; i++) begin : g_sig
        rgbfmt_launch u_launch (
            .clk(clk), .rst_n(rst_n), .en(st_q.ctrl.en),
            .neg(st_q.ctrl.neg[i]), .rise_q(st_q.sig[i]), .pin(pins[i])
        );
    end

    assign pnl_data  = st_q.data;
    assign pnl_hs    = pins[2];
    assign pnl_vs    = pins[1];
    assign pnl_de    = pins[0];
    assign pnl_clk   = st_q.ctrl.en & (clk ^ st_q.clk_inv);
    assign cfg_rdata = ctrl_hit ? {{(32-CTRL_W){1'b0}}, st_q.ctrl} : ID_WORD;

    // R1
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ctrl_hit) |=> (st_q.ctrl == $past(cfg_wdata[CTRL_W-1:0])));

    // R3
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(st_q.ctrl.en) && !$past(st_q.ctrl.en, 2)) |->
        (pnl_data == '0 && pnl_hs == 1'b0 && pnl_vs == 1'b0 && pnl_de == 1'b0));

    // R2
    always_comb begin
        if (rst_n && !ctrl_hit) begin
            id_read_chk: assert (cfg_rdata == ID_WORD);
        end
    end

    // R12
    always_comb begin
        if (rst_n && !st_q.ctrl.en) begin
            clk_gate_chk: assert (pnl_clk == 1'b0);
        end
    end
endmodule

// File: tb/tb_rgb_panel_fmt.sv
`timescale 1ns/1ps
module tb_rgb_panel_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [23:0] pix_rgb = '0;
    logic        pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
    logic [23:0] pnl_data;
    logic        pnl_hs, pnl_vs, pnl_de, pnl_clk;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    rgb_panel_fmt dut (.*);

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_data(input logic [16:0] c, input logic [23:0] p);
        logic [7:0] r, g, b, h, m, l;
        r = p[23:16]; g = p[15:8]; b = p[7:0];
        case (c[15:14])
            2'd0: begin h = r; m = g; l = b; end
            2'd1: begin h = b; m = g; l = r; end
            2'd2: begin h = g; m = r; l = b; end
            default: begin h = b; m = r; l = g; end
        endcase
        if (!c[0]) return 24'h0;
        case (c[13:11])
            3'd1: return (24'(h >> 3) << 11) | (24'(m >> 2) << 5) | 24'(l >> 3);
            3'd2: return (24'(h >> 3) << 16) | (24'(m >> 2) << 8) | 24'(l >> 3);
            3'd3: return (24'(h >> 3) << 17) | (24'(m >> 2) << 8) | (24'(l >> 3) << 1);
            3'd4: return (24'(h >> 2) << 12) | (24'(m >> 2) << 6) | 24'(l >> 2);
            3'd5: return (24'(h >> 2) << 16) | (24'(m >> 2) << 8) | 24'(l >> 2);
            3'd6: return {h, m, l};
            default: return 24'h0;
        endcase
    endfunction

    // returns {hs, vs, de} pin levels for the rising-edge path
    function automatic logic [2:0] ref_sig(input logic [16:0] c, input logic hs, input logic vs, input logic de);
        logic [2:0] s;
        s = {hs, vs, c[16] ? (hs ^ vs) : de};
        for (int i = 0; i < 3; i++) begin
            if (c[1 + i]) s[i] = 1'b0;
            s[i] = s[i] ^ c[7 + i];
        end
        return c[0] ? s : 3'b000;
    endfunction

    // Called at 5 ns after a rising edge; returns at the same phase.
    task automatic run_cfg(input logic [16:0] c, input int cycles, input string tag);
        logic [23:0] d_cur;
        logic [2:0]  s_cur, s_prev, s_exp, s_act;
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = {15'h7abc, c};
        @(posedge clk); #5;
        cfg_we = 1'b0;
        #1;
        check(cfg_rdata == {15'b0, c}, "R1 readback", cfg_rdata, {15'b0, c});
        d_cur = '0; s_cur = '0; s_prev = '0;
        for (int i = 0; i < cycles; i++) begin
            pix_rgb = 24'($urandom); pix_hs = 1'($urandom); pix_vs = 1'($urandom); pix_de = 1'($urandom);
            d_cur  = ref_data(c, pix_rgb);
            s_prev = s_cur;
            s_cur  = ref_sig(c, pix_hs, pix_vs, pix_de);
            @(posedge clk); #3;
            if (i >= 2) begin
                for (int k = 0; k < 3; k++) s_exp[k] = c[4 + k] ? s_prev[k] : s_cur[k];
                s_act = {pnl_hs, pnl_vs, pnl_de};
                check(pnl_data == d_cur, {tag, " data R4,R5,R6,R7,R13"}, {8'h0, pnl_data}, {8'h0, d_cur});
                check(s_act == s_exp, {tag, " strobes R8,R9,R10,R11"}, {29'h0, s_act}, {29'h0, s_exp});
                check(pnl_clk == (c[0] & ~c[10]), {tag, " clock R12,R3"}, {31'h0, pnl_clk}, {31'h0, c[0] & ~c[10]});
            end
            #3;
        end
    endtask

    initial begin
        #(20 * 190000);
        check(1'b0, "watchdog R13", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        repeat (3) @(posedge clk);
        #5;
        check(pnl_data == 24'h0 && {pnl_hs, pnl_vs, pnl_de} == 3'b0, "R3 reset outputs", {8'h0, pnl_data}, 0);
        rst_n = 1'b1;
        #1;
        check(cfg_rdata == 32'h0, "R1 reset control", cfg_rdata, 0);
        // R2: every non-control address
        for (int a = 1; a < 16; a++) begin
            cfg_addr = 4'(a); #1;
            check(cfg_rdata == 32'h00647069, "R2 id word", cfg_rdata, 32'h00647069);
        end
        cfg_addr = 4'd0;
        @(posedge clk); #5;
        // R3: disabled with every other bit set
        run_cfg(17'h1fffe, 8, "R3 disabled");
        // R4 R5 R6 R7: every order and layout, plain strobes
        for (int f = 0; f < 8; f++)
            for (int o = 0; o < 4; o++)
                run_cfg({1'b0, 2'(o), 3'(f), 10'b0, 1'b1}, 6, "R4 order/layout");
        // R8 R9 R10 R11 R12 directed
        run_cfg(17'h0_3381, 8, "R8 invert all");     // fmt6, inv 111
        run_cfg(17'h0_338f, 8, "R9 disable+invert"); // fmt6, inv, dis 111
        run_cfg(17'h0_3071, 10, "R10 falling launch");
        run_cfg(17'h1_3001, 10, "R11 composite sync");
        run_cfg(17'h1_3083, 8, "R11 composite inv dis");
        run_cfg(17'h0_3401, 6, "R12 clock invert");
        // R13: enable toggled off then on restarts cleanly
        run_cfg(17'h0_3000, 4, "R13 off");
        run_cfg(17'h0_3001, 6, "R13 on");
        // random mix
        for (int n = 0; n < 40; n++)
            run_cfg(17'($urandom) | 17'h1, 12, "random");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule